// File: doc/BRIEF.md
# Dadda-Tree Multiply-Accumulate Unit

This block multiplies two 4-bit unsigned operands and adds the product into an 8-bit running sum. The 4x4 multiplier is built by hand. Sixteen two-input AND gates form the partial-product bits. Half and full adders then compress those bits column by column, following the Dadda height schedule of 3 and then 2. One carry-propagate adder sums the two rows that remain. No inferred multiplier is used anywhere in the datapath.

The accumulator is a single register. Each cycle in which `mac_vld_i` is high, the product of that cycle's operands is added to it. The sum wraps modulo 256. Raising `mac_clr_i` starts a new dot product with no idle cycle. With a valid operand pair present, the register takes that pair's product. Without one, it takes zero. A typical user streams pairs of low-precision elements, one per cycle, and pulses clear together with the first pair of each new vector.

Top module: `dadda_mac`

## Requirements
- R1: While the reset is asserted, and on the first clock edges after it is released, `acc_o` reads 0.
- R2: For every one of the 256 unsigned pairs `op_a_i`, `op_b_i`, the tree's product equals the arithmetic product. The largest product, 225, fits in 8 bits, so the final adder never carries out. The product is observed through a clear-and-valid load.
- R3: When `mac_vld_i`=1 and `mac_clr_i`=0 at a rising edge, `acc_o` becomes (previous `acc_o` + `op_a_i`*`op_b_i`) mod 256. Sums above 255 wrap.
- R4: When `mac_vld_i`=0 and `mac_clr_i`=0 at a rising edge, `acc_o` keeps its value. Operand values have no effect in this case.
- R5: When `mac_clr_i`=1 and `mac_vld_i`=1 at a rising edge, `acc_o` becomes `op_a_i`*`op_b_i`. The previous sum is discarded.
- R6: When `mac_clr_i`=1 and `mac_vld_i`=0 at a rising edge, `acc_o` becomes 0.
- R7: Over a stream of random operand pairs with random valid and clear strobes, `acc_o` matches a modulo-256 reference after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| mac_vld_i | input | 1 | Operand pair present this cycle |
| mac_clr_i | input | 1 | Restart the running sum |
| op_a_i | input | 4 | Unsigned multiplicand |
| op_b_i | input | 4 | Unsigned multiplier |
| acc_o | output | 8 | Running sum, modulo 256 |

## Verification
The embedded properties check four update rules on every clocked cycle: hold, accumulate, load-on-clear and zero-on-clear. The accumulate and load rules are compared against an arithmetic product, and the tree's output is checked never to exceed 225. Only the bench's scenarios can show that every one of the 256 operand pairs reaches the accumulator correctly. The same holds for the reset value after release, for wrap-around on chosen large products, and for agreement with an independent reference over long random streams of mixed strobes.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = 8;
  localparam int SYNC_STAGES = 2;

  typedef logic [OP_W-1:0]  op_t;
  typedef logic [PROD_W-1:0] prod_t;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/mac_cells.sv
module mac_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

module mac_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/mac_cpa.sv
module mac_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cy;
  assign cy[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_bit
    mac_fa u_fa (.x(x[k]), .y(y[k]), .z(cy[k]), .s(s[k]), .c(cy[k+1]));
  end
  assign co = cy[W];
endmodule

// File: rtl/dadda_tree4.sv
module dadda_tree4
  import mac_pkg::*;
(
  input  op_t   a,
  input  op_t   b,
  output prod_t prod,
  output logic  cpa_co
);
  // partial products: pp[i][j] = a[i] & b[j], weight i+j
  logic [OP_W-1:0] pp [OP_W];
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end

  // stage 1, height limit 3: columns 3 and 4
  logic s1, c1, s2, c2;
  mac_ha u_h1 (.x(pp[0][3]), .y(pp[1][2]), .s(s1), .c(c1));
  mac_ha u_h2 (.x(pp[1][3]), .y(pp[2][2]), .s(s2), .c(c2));

  // stage 2, height limit 2: columns 2..5
  logic s3, c3, s4, c4, s5, c5, s6, c6;
  mac_ha u_h3 (.x(pp[0][2]), .y(pp[1][1]), .s(s3), .c(c3));
  mac_fa u_f1 (.x(s1), .y(pp[2][1]), .z(pp[3][0]), .s(s4), .c(c4));
  mac_fa u_f2 (.x(s2), .y(pp[3][1]), .z(c1),       .s(s5), .c(c5));
  mac_fa u_f3 (.x(pp[2][3]), .y(pp[3][2]), .z(c2), .s(s6), .c(c6));

  // two remaining rows
  prod_t row_x, row_y;
  assign row_x = {1'b0, pp[3][3], s6, s5, s4, s3, pp[0][1], pp[0][0]};
  assign row_y = {1'b0, c6, c5, c4, c3, pp[2][0], pp[1][0], 1'b0};

  mac_cpa #(.W(PROD_W)) u_cpa (.x(row_x), .y(row_y), .s(prod), .co(cpa_co));
endmodule

// File: rtl/dadda_mac.sv
module dadda_mac
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mac_vld_i,
  input  logic       mac_clr_i,
  input  logic [3:0] op_a_i,
  input  logic [3:0] op_b_i,
  output logic [7:0] acc_o
);
  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  prod_t prod;
  logic  tree_co;
  dadda_tree4 u_tree (.a(op_a_i), .b(op_b_i), .prod(prod), .cpa_co(tree_co));

  acc_t acc_q, acc_nxt;
  logic acc_en;

  always_comb begin
    acc_en  = mac_vld_i | mac_clr_i;
    acc_nxt = acc_q;
    if (mac_clr_i)      acc_nxt = mac_vld_i ? prod : '0;
    else if (mac_vld_i) acc_nxt = acc_q + prod;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  acc_q <= '0;
    else if (acc_en) acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;

  // R2: tree output within 4x4 range, final adder never carries out
  p_prod_range_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prod <= 8'd225) && !tree_co);

  // R3: accumulate
  p_accum_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mac_vld_i && !mac_clr_i) |=>
      acc_q == 8'($past(acc_q) + 8'($past(op_a_i)) * 8'($past(op_b_i))));

  // R4: hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mac_vld_i && !mac_clr_i) |=> $stable(acc_q));

  // R5: clear with valid loads product
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mac_vld_i && mac_clr_i) |=>
      acc_q == 8'(8'($past(op_a_i)) * 8'($past(op_b_i))));

  // R6: clear without valid zeroes
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mac_vld_i && mac_clr_i) |=> acc_q == 8'd0);
endmodule

// File: tb/sim_dadda_mac.sv
module sim_dadda_mac;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld, clr;
  logic [3:0] a, b;
  logic [7:0] acc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  dadda_mac u0 (.clk(clk), .rst_n(rst_n), .mac_vld_i(vld), .mac_clr_i(clr),
                .op_a_i(a), .op_b_i(b), .acc_o(acc));

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (acc !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_o=%0d expected %0d", req, acc, exp);
    end
  endtask

  // drive at negedge, let one posedge happen, come back to negedge
  task automatic step(input logic v, input logic c, input logic [3:0] x, input logic [3:0] y);
    vld = v; clr = c; a = x; b = y;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; vld = 1'b0; clr = 1'b0; a = 4'hF; b = 4'hF;
    repeat (3) @(negedge clk);
    check("R1", 8'd0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'hF, 4'hF); // within sync window: ignored
    check("R1", 8'd0);
    repeat (3) step(1'b0, 1'b0, 4'h0, 4'h0);
    check("R1", 8'd0);
  endtask

  task automatic t_exhaustive_r2();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(1'b1, 1'b1, 4'(x), 4'(y));
        check("R2", 8'(x * y));
      end
    end
  endtask

  task automatic t_wrap_r3();
    step(1'b1, 1'b1, 4'd15, 4'd15); check("R5", 8'd225);
    step(1'b1, 1'b0, 4'd15, 4'd15); check("R3", 8'd194);
    step(1'b1, 1'b0, 4'd15, 4'd15); check("R3", 8'd163);
    step(1'b1, 1'b0, 4'd3,  4'd5);  check("R3", 8'd178);
  endtask

  task automatic t_hold_r4();
    step(1'b1, 1'b1, 4'd7, 4'd9); check("R5", 8'd63);
    step(1'b0, 1'b0, 4'd15, 4'd15); check("R4", 8'd63);
    step(1'b0, 1'b0, 4'd2, 4'd11);  check("R4", 8'd63);
  endtask

  task automatic t_clear_r5_r6();
    step(1'b1, 1'b1, 4'd12, 4'd10); check("R5", 8'd120);
    step(1'b1, 1'b1, 4'd1,  4'd1);  check("R5", 8'd1);
    step(1'b0, 1'b1, 4'd15, 4'd15); check("R6", 8'd0);
    step(1'b1, 1'b0, 4'd4,  4'd4);  check("R3", 8'd16);
  endtask

  task automatic t_random_r7();
    logic [7:0] ref_sum;
    step(1'b0, 1'b1, 4'd0, 4'd0);
    ref_sum = 8'd0;
    check("R7", ref_sum);
    for (int k = 0; k < 2000; k++) begin
      logic v, c;
      logic [3:0] x, y;
      v = ($urandom % 4) != 0;
      c = ($urandom % 16) == 0;
      x = 4'($urandom); y = 4'($urandom);
      if (c)      ref_sum = v ? 8'(x * y) : 8'd0;
      else if (v) ref_sum = 8'(ref_sum + x * y);
      step(v, c, x, y);
      check("R7", ref_sum);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    t_reset_r1();
    t_exhaustive_r2();
    t_wrap_r3();
    t_hold_r4();
    t_clear_r5_r6();
    t_random_r7();
    finish_run();
  end
endmodule